// File: doc/BRIEF.md
# Exception Entry Dispatcher

This block turns one pending exception into the full set of state updates a core needs to enter its handler. The core presents an exception vector code, a flavour selector, the current instruction address, the current machine-state word and a small cause code together with a one-cycle valid strobe. One clock later the block reports which save-register pair to write and the values for it. Machine check in the vectored flavour also writes an alternate pair. The block also returns the new machine-state word and the handler fetch address. A code the block cannot map returns an error pulse instead.

Three flavours are supported. Flavour code 0 is the classic core; code 3 behaves the same way. Code 1 is the 4xx-style core and code 2 is the embedded vectored core. In the vectored flavour the handler address is a prefix register OR-ed with one of twenty-two per-cause offset registers. These registers live inside the block and are loaded through a single-word write port. Offsets 0 to 15 sit at write addresses 0 to 15. The six upper-bank offsets, for indices 32 to 37, sit at addresses 16 to 21. The prefix sits at address 31, and writes to any other address are dropped. An entry and a write in the same cycle see the value from before the write.

Top module: `exc_entry_dispatch`

## Requirements
- R1: After reset every output is zero. Each valid strobe gives exactly one done_o pulse on the next clock and no other cycle has done_o set.
- R2: In flavour 2 the handler address is prefix OR offset[idx]. Indices 0..15 use write addresses 0..15 and indices 32..37 use write addresses 16..21. The prefix is at write address 31.
- R3: An unknown code in any flavour gives err_o=1 with save_we_o=0 and alt_we_o=0, and leaves every data output unchanged. In flavour 2, an index in 16..31 is treated the same way.
- R4: Vector codes map to cause indices as follows. 0x0100 reset→0, 0x0200 machine check→1, 0x0300 data storage→2, 0x0400 instruction storage→3, 0x0500 external→4, 0x0600 alignment→5, 0x0700 program→6 (15 when trap), 0x0800 FP unavailable→7, 0x0C00 system call→8, 0x0F20 auxiliary unit→9, 0x1000 programmable timer→10, 0x1010 fixed timer→11, 0x1020 watchdog→12, 0x1100 data TLB miss→13, 0x1200 instruction TLB miss→14. Extended code 0x2000+32*k for k in 0..21 maps to index 16+k.
- R5: save_pair_o encodes 0 as the base pair, 1 as the second pair, 2 as the critical pair and 3 as the machine-check pair. Reset uses pair 1 in flavour 1 and pair 2 in flavour 2. Machine check uses pair 1 in flavour 1 and pair 3 in flavour 2. Watchdog uses pair 2 in flavour 2. Every other case uses pair 0.
- R6: Machine check clears state bit 12 (machine-check enable) in the new word. In flavour 2 it also clears bit 17 (critical enable) and asserts alt_we_o, which asks for the same saved values to be written into the critical pair.
- R7: For a program exception the saved word keeps its low 16 bits, has its upper 16 bits cleared, and then has one flag ORed in. The flag is 0x00040000 for cause[1:0]=1 (floating point), 0x00020000 for cause[1:0]=2 (trap) and 0x00010000 for any other value.
- R8: Alignment, program and FP-unavailable entries save pc_i-4. All other entries save pc_i.
- R9: The new state word is msr_i with bits 5, 4, 1 and 18 (instruction translation, data translation, recoverable, power-save) cleared. Bit 0 (little-endian) is copied from bit 16. In flavour 2, bit 31 (computation mode) is copied from bit 25.
- R10: Outside flavour 2 the handler address is the vector code. For reset in flavours 0 and 3 it is (code plus 0xFFC00 when msr_i bit 6 is set) OR 0xFFC00000.
- R11: Data storage, FP unavailable and the three timer codes save msr_i with its upper 16 bits cleared. Instruction storage does the same and then ORs in cause_i. All other codes save msr_i unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Vector register write strobe |
| cfg_addr | input | 5 | Vector register write address |
| cfg_data | input | 32 | Vector register write data |
| valid_i | input | 1 | Exception entry request |
| code_i | input | 16 | Exception vector code |
| flavour_i | input | 2 | Core flavour: 0 classic, 1 4xx-style, 2 vectored, 3 classic |
| pc_i | input | 32 | Current instruction address |
| msr_i | input | 32 | Current machine-state word |
| cause_i | input | 16 | Cause code |
| done_o | output | 1 | Entry processed |
| err_o | output | 1 | Unmapped exception |
| save_we_o | output | 1 | Write the selected save pair |
| save_pair_o | output | 2 | Selected save pair |
| alt_we_o | output | 1 | Also write the critical pair |
| save_pc_o | output | 32 | Address to save |
| save_msr_o | output | 32 | State word to save |
| new_msr_o | output | 32 | State word for the handler |
| handler_o | output | 32 | Handler fetch address |

## Verification
On every cycle the assertions check that done_o follows the strobe by one clock, that an error never comes with a save write, and that the data outputs hold across an error. They also check that alt_we_o appears only together with a machine-check pair write, and that every entry leaves translation, recoverable and power-save cleared. The values themselves can only be shown by the bench's scenarios, which are compared against a behavioural model. These values are the index table, the pair choice per flavour, the program and cause encodings of the saved word, the classic reset vector and the two offset banks. The same applies to the rejection of indices 16 to 31 and to a write in the same cycle as an entry.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W  = 16;
  localparam int IDX_W   = 6;

  typedef enum logic [1:0] {FLV_CLASSIC = 2'd0, FLV_4XX = 2'd1, FLV_EMB = 2'd2} flavour_e;
  typedef enum logic [1:0] {PAIR_BASE = 2'd0, PAIR_SECOND = 2'd1, PAIR_CRIT = 2'd2, PAIR_MCHK = 2'd3} pair_e;
  typedef enum logic [1:0] {SW_KEEP = 2'd0, SW_CLRHI = 2'd1, SW_CAUSE = 2'd2, SW_PROG = 2'd3} sw_op_e;

  // machine-state word bit positions
  localparam int B_LE  = 0;
  localparam int B_RI  = 1;
  localparam int B_DR  = 4;
  localparam int B_IR  = 5;
  localparam int B_IP  = 6;
  localparam int B_ME  = 12;
  localparam int B_ILE = 16;
  localparam int B_CE  = 17;
  localparam int B_POW = 18;
  localparam int B_ICM = 25;
  localparam int B_CM  = 31;

  // vector codes
  localparam logic [CODE_W-1:0] EC_RESET  = 16'h0100;
  localparam logic [CODE_W-1:0] EC_MCHK   = 16'h0200;
  localparam logic [CODE_W-1:0] EC_DSTOR  = 16'h0300;
  localparam logic [CODE_W-1:0] EC_ISTOR  = 16'h0400;
  localparam logic [CODE_W-1:0] EC_EXTIRQ = 16'h0500;
  localparam logic [CODE_W-1:0] EC_ALIGN  = 16'h0600;
  localparam logic [CODE_W-1:0] EC_PROG   = 16'h0700;
  localparam logic [CODE_W-1:0] EC_NOFP   = 16'h0800;
  localparam logic [CODE_W-1:0] EC_SCALL  = 16'h0C00;
  localparam logic [CODE_W-1:0] EC_AUXU   = 16'h0F20;
  localparam logic [CODE_W-1:0] EC_PIT    = 16'h1000;
  localparam logic [CODE_W-1:0] EC_FIT    = 16'h1010;
  localparam logic [CODE_W-1:0] EC_WDOG   = 16'h1020;
  localparam logic [CODE_W-1:0] EC_DTLB   = 16'h1100;
  localparam logic [CODE_W-1:0] EC_ITLB   = 16'h1200;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_pkg::*;
#(
  parameter int LO_SLOTS  = 16,
  parameter int HI_BASE   = 32,
  parameter int EXT_SLOTS = 22
) (
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        flavour,
  input  logic [1:0]        prog_kind,
  output logic [IDX_W-1:0]  idx,
  output logic              err,
  output pair_e             pair,
  output logic              alt,
  output logic              use_cur,
  output sw_op_e            sw_op,
  output logic              is_mchk,
  output logic              is_reset
);
  logic is_emb, is_4xx, known;
  int   idx_n;

  assign is_emb = (flavour == FLV_EMB);
  assign is_4xx = (flavour == FLV_4XX);

  always_comb begin
    known    = 1'b1;
    idx_n    = 0;
    use_cur  = 1'b0;
    sw_op    = SW_KEEP;
    is_mchk  = 1'b0;
    is_reset = 1'b0;
    pair     = PAIR_BASE;
    alt      = 1'b0;
    case (code)
      EC_RESET: begin
        idx_n    = 0;
        is_reset = 1'b1;
        pair     = is_4xx ? PAIR_SECOND : (is_emb ? PAIR_CRIT : PAIR_BASE);
      end
      EC_MCHK: begin
        idx_n   = 1;
        is_mchk = 1'b1;
        pair    = is_4xx ? PAIR_SECOND : (is_emb ? PAIR_MCHK : PAIR_BASE);
        alt     = is_emb;
      end
      EC_DSTOR:  begin idx_n = 2; sw_op = SW_CLRHI; end
      EC_ISTOR:  begin idx_n = 3; sw_op = SW_CAUSE; end
      EC_EXTIRQ: idx_n = 4;
      EC_ALIGN:  begin idx_n = 5; use_cur = 1'b1; end
      EC_PROG: begin
        idx_n   = (prog_kind == 2'd2) ? 15 : 6;
        use_cur = 1'b1;
        sw_op   = SW_PROG;
      end
      EC_NOFP:   begin idx_n = 7; use_cur = 1'b1; sw_op = SW_CLRHI; end
      EC_SCALL:  idx_n = 8;
      EC_AUXU:   idx_n = 9;
      EC_PIT:    begin idx_n = 10; sw_op = SW_CLRHI; end
      EC_FIT:    begin idx_n = 11; sw_op = SW_CLRHI; end
      EC_WDOG: begin
        idx_n = 12;
        sw_op = SW_CLRHI;
        pair  = is_emb ? PAIR_CRIT : PAIR_BASE;
      end
      EC_DTLB:   idx_n = 13;
      EC_ITLB:   idx_n = 14;
      default: begin
        if (code[15:13] == 3'b001 && code[4:0] == 5'd0 && int'(code[12:5]) < EXT_SLOTS)
          idx_n = LO_SLOTS + int'(code[12:5]);
        else
          known = 1'b0;
      end
    endcase
  end

  assign idx = IDX_W'(idx_n);
  assign err = !known || (is_emb && idx_n >= LO_SLOTS && idx_n < HI_BASE);
endmodule

// File: rtl/exc_vec_store.sv
module exc_vec_store
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int OFS_W   = 16,
  parameter int N_LO    = 16,
  parameter int N_HI    = 6,
  parameter int HI_BASE = 32,
  parameter int AW      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_vec
);
  localparam int DEPTH    = N_LO + N_HI;
  localparam int SLOT_W   = $clog2(DEPTH);
  localparam int PFX_ADDR = (1 << AW) - 1;

  logic [OFS_W-1:0]  ofs_mem [DEPTH];
  logic [XLEN-1:0]   prefix_q;
  logic [SLOT_W-1:0] slot;
  logic              hit;

  // offset storage: no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en && int'(wr_addr) < DEPTH)
      ofs_mem[SLOT_W'(wr_addr)] <= wr_data[OFS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      prefix_q <= '0;
    else if (wr_en && int'(wr_addr) == PFX_ADDR)
      prefix_q <= wr_data;
  end

  generate
    if (N_HI > 0) begin : g_two_banks
      always_comb begin
        if (int'(rd_idx) < N_LO) begin
          hit  = 1'b1;
          slot = SLOT_W'(rd_idx);
        end else if (int'(rd_idx) >= HI_BASE && int'(rd_idx) < HI_BASE + N_HI) begin
          hit  = 1'b1;
          slot = SLOT_W'(int'(rd_idx) - HI_BASE + N_LO);
        end else begin
          hit  = 1'b0;
          slot = '0;
        end
      end
    end else begin : g_one_bank
      always_comb begin
        hit  = int'(rd_idx) < N_LO;
        slot = hit ? SLOT_W'(rd_idx) : '0;
      end
    end
  endgenerate

  assign rd_vec = prefix_q | (hit ? XLEN'(ofs_mem[slot]) : '0);
endmodule

// File: rtl/exc_state_build.sv
module exc_state_build
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 16
) (
  input  logic [XLEN-1:0]    msr,
  input  logic [CAUSE_W-1:0] cause,
  input  sw_op_e             sw_op,
  input  logic               is_emb,
  input  logic               is_mchk,
  output logic [XLEN-1:0]    saved,
  output logic [XLEN-1:0]    nxt
);
  localparam logic [XLEN-1:0] LOW_MASK   = XLEN'(32'h0000_FFFF);
  localparam logic [XLEN-1:0] FLAG_FP    = XLEN'(32'h0004_0000);
  localparam logic [XLEN-1:0] FLAG_TRAP  = XLEN'(32'h0002_0000);
  localparam logic [XLEN-1:0] FLAG_OTHER = XLEN'(32'h0001_0000);

  logic [XLEN-1:0] prog_flag;

  always_comb begin
    case (cause[1:0])
      2'd1:    prog_flag = FLAG_FP;
      2'd2:    prog_flag = FLAG_TRAP;
      default: prog_flag = FLAG_OTHER;
    endcase
  end

  always_comb begin
    case (sw_op)
      SW_CLRHI: saved = msr & LOW_MASK;
      SW_CAUSE: saved = (msr & LOW_MASK) | XLEN'(cause);
      SW_PROG:  saved = (msr & LOW_MASK) | prog_flag;
      default:  saved = msr;
    endcase
  end

  always_comb begin
    nxt        = msr;
    nxt[B_IR]  = 1'b0;
    nxt[B_DR]  = 1'b0;
    nxt[B_RI]  = 1'b0;
    nxt[B_POW] = 1'b0;
    nxt[B_LE]  = msr[B_ILE];
    if (is_mchk) nxt[B_ME] = 1'b0;
    if (is_mchk && is_emb) nxt[B_CE] = 1'b0;
    if (is_emb) nxt[B_CM] = msr[B_ICM];
  end
endmodule

// File: rtl/exc_entry_dispatch.sv
module exc_entry_dispatch
  import exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 16,
  parameter int OFS_W     = 16,
  parameter int N_LO      = 16,
  parameter int N_HI      = 6,
  parameter int HI_BASE   = 32,
  parameter int EXT_SLOTS = 22,
  parameter int AW        = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [XLEN-1:0]    cfg_data,
  input  logic               valid_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [1:0]         flavour_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    msr_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               done_o,
  output logic               err_o,
  output logic               save_we_o,
  output logic [1:0]         save_pair_o,
  output logic               alt_we_o,
  output logic [XLEN-1:0]    save_pc_o,
  output logic [XLEN-1:0]    save_msr_o,
  output logic [XLEN-1:0]    new_msr_o,
  output logic [XLEN-1:0]    handler_o
);
  localparam logic [XLEN-1:0] RST_ADD = XLEN'(32'h000F_FC00);
  localparam logic [XLEN-1:0] RST_HI  = XLEN'(32'hFFC0_0000);
  localparam logic [XLEN-1:0] INSN_SZ = XLEN'(4);

  logic [IDX_W-1:0] idx;
  logic             dec_err, alt, use_cur, is_mchk, is_reset, is_emb, is_classic;
  pair_e            pair;
  sw_op_e           sw_op;
  logic [XLEN-1:0]  vec_addr, saved_w, next_w, handler_n, save_pc_n;

  exc_decode #(.LO_SLOTS(N_LO), .HI_BASE(HI_BASE), .EXT_SLOTS(EXT_SLOTS)) u_dec (
    .code(code_i), .flavour(flavour_i), .prog_kind(cause_i[1:0]),
    .idx(idx), .err(dec_err), .pair(pair), .alt(alt), .use_cur(use_cur),
    .sw_op(sw_op), .is_mchk(is_mchk), .is_reset(is_reset)
  );

  exc_vec_store #(.XLEN(XLEN), .OFS_W(OFS_W), .N_LO(N_LO), .N_HI(N_HI),
                  .HI_BASE(HI_BASE), .AW(AW)) u_vec (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_data),
    .rd_idx(idx), .rd_vec(vec_addr)
  );

  exc_state_build #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_state (
    .msr(msr_i), .cause(cause_i), .sw_op(sw_op), .is_emb(is_emb),
    .is_mchk(is_mchk), .saved(saved_w), .nxt(next_w)
  );

  assign is_emb     = (flavour_i == FLV_EMB);
  assign is_classic = !is_emb && (flavour_i != FLV_4XX);

  always_comb begin
    if (is_emb)
      handler_n = vec_addr;
    else if (is_classic && is_reset)
      handler_n = (msr_i[B_IP] ? XLEN'(code_i) + RST_ADD : XLEN'(code_i)) | RST_HI;
    else
      handler_n = XLEN'(code_i);
  end

  assign save_pc_n = use_cur ? pc_i - INSN_SZ : pc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      save_we_o   <= 1'b0;
      alt_we_o    <= 1'b0;
      save_pair_o <= '0;
      save_pc_o   <= '0;
      save_msr_o  <= '0;
      new_msr_o   <= '0;
      handler_o   <= '0;
    end else begin
      done_o    <= valid_i;
      err_o     <= valid_i && dec_err;
      save_we_o <= valid_i && !dec_err;
      alt_we_o  <= valid_i && !dec_err && alt;
      if (valid_i && !dec_err) begin
        save_pair_o <= pair;
        save_pc_o   <= save_pc_n;
        save_msr_o  <= saved_w;
        new_msr_o   <= next_w;
        handler_o   <= handler_n;
      end
    end
  end

  // R1: one done pulse per strobe, one clock later
  assert_done_follows_R1: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);
  assert_done_source_R1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(valid_i));
  // R3: an error never writes and leaves data outputs alone
  assert_err_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!save_we_o && !alt_we_o));
  assert_err_holds_R3: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($stable(handler_o) && $stable(new_msr_o) && $stable(save_pc_o)));
  // R6: alternate write only with a machine-check pair write
  assert_alt_mchk_R6: assert property (@(posedge clk) disable iff (rst)
    alt_we_o |-> (save_we_o && save_pair_o == PAIR_MCHK));
  // R9: every entry leaves translation, recoverable and power-save cleared
  assert_entry_state_R9: assert property (@(posedge clk) disable iff (rst)
    save_we_o |-> (!new_msr_o[B_IR] && !new_msr_o[B_DR] && !new_msr_o[B_RI] && !new_msr_o[B_POW]));
endmodule

// File: tb/exc_entry_dispatch_test.sv
module exc_entry_dispatch_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        valid_i = 1'b0;
  logic [15:0] code_i = '0;
  logic [1:0]  flavour_i = '0;
  logic [31:0] pc_i = '0, msr_i = '0;
  logic [15:0] cause_i = '0;
  logic        done_o, err_o, save_we_o, alt_we_o;
  logic [1:0]  save_pair_o;
  logic [31:0] save_pc_o, save_msr_o, new_msr_o, handler_o;

  int n_chk = 0, n_bad = 0;

  exc_entry_dispatch uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .valid_i(valid_i), .code_i(code_i), .flavour_i(flavour_i), .pc_i(pc_i),
    .msr_i(msr_i), .cause_i(cause_i), .done_o(done_o), .err_o(err_o),
    .save_we_o(save_we_o), .save_pair_o(save_pair_o), .alt_we_o(alt_we_o),
    .save_pc_o(save_pc_o), .save_msr_o(save_msr_o), .new_msr_o(new_msr_o),
    .handler_o(handler_o)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic err; logic alt; logic [1:0] pair;
    logic [31:0] spc; logic [31:0] smsr; logic [31:0] nmsr; logic [31:0] hnd;
  } exp_t;

  logic [15:0] m_ofs [22];
  logic [31:0] m_pfx;
  logic        e_done, e_err, e_we, e_alt;
  logic [1:0]  e_pair;
  logic [31:0] e_spc, e_smsr, e_nmsr, e_hnd;

  function automatic exp_t model(input logic [15:0] c, input logic [1:0] f,
                                 input logic [31:0] pc, input logic [31:0] m, input logic [15:0] cs);
    exp_t e;
    int   idx;
    bit   cur, emb, x4;
    logic [31:0] lo;
    e = '0; idx = -1; cur = 0; emb = (f == 2); x4 = (f == 1);
    lo = {16'h0, m[15:0]};
    e.smsr = m;
    case (c)
      16'h0100: begin idx = 0; e.pair = x4 ? 2'd1 : (emb ? 2'd2 : 2'd0); end
      16'h0200: begin idx = 1; e.pair = x4 ? 2'd1 : (emb ? 2'd3 : 2'd0); e.alt = emb; end
      16'h0300: begin idx = 2; e.smsr = lo; end
      16'h0400: begin idx = 3; e.smsr = lo | {16'h0, cs}; end
      16'h0500: idx = 4;
      16'h0600: begin idx = 5; cur = 1; end
      16'h0700: begin
        cur = 1;
        idx = (cs[1:0] == 2) ? 15 : 6;
        e.smsr = lo | ((cs[1:0] == 1) ? 32'h40000 : (cs[1:0] == 2) ? 32'h20000 : 32'h10000);
      end
      16'h0800: begin idx = 7; cur = 1; e.smsr = lo; end
      16'h0C00: idx = 8;
      16'h0F20: idx = 9;
      16'h1000: begin idx = 10; e.smsr = lo; end
      16'h1010: begin idx = 11; e.smsr = lo; end
      16'h1020: begin idx = 12; e.smsr = lo; if (emb) e.pair = 2'd2; end
      16'h1100: idx = 13;
      16'h1200: idx = 14;
      default: if (c >= 16'h2000 && c <= 16'h22A0 && c % 32 == 0) idx = 16 + (c - 16'h2000) / 32;
    endcase
    e.err = (idx < 0) || (emb && idx >= 16 && idx < 32);
    if (e.err) e.alt = 0;
    e.spc = cur ? pc - 4 : pc;
    e.nmsr = m & ~32'h0004_0032;
    e.nmsr[0] = m[16];
    if (c == 16'h0200) begin
      e.nmsr[12] = 1'b0;
      if (emb) e.nmsr[17] = 1'b0;
    end
    if (emb) e.nmsr[31] = m[25];
    if (emb) begin
      if (idx >= 0 && idx < 16) e.hnd = m_pfx | {16'h0, m_ofs[idx]};
      else if (idx >= 32 && idx < 38) e.hnd = m_pfx | {16'h0, m_ofs[idx - 16]};
      else e.hnd = m_pfx;
    end else if (c == 16'h0100 && !x4)
      e.hnd = (m[6] ? 32'(c) + 32'hFFC00 : 32'(c)) | 32'hFFC00000;
    else
      e.hnd = 32'(c);
    return e;
  endfunction

  // reference model: updated on the same edge as the design
  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      e_done <= 0; e_err <= 0; e_we <= 0; e_alt <= 0; e_pair <= 0;
      e_spc <= 0; e_smsr <= 0; e_nmsr <= 0; e_hnd <= 0;
      m_pfx = '0;
    end else begin
      e = model(code_i, flavour_i, pc_i, msr_i, cause_i);
      e_done <= valid_i;
      e_err  <= valid_i && e.err;
      e_we   <= valid_i && !e.err;
      e_alt  <= valid_i && e.alt;
      if (valid_i && !e.err) begin
        e_pair <= e.pair; e_spc <= e.spc; e_smsr <= e.smsr; e_nmsr <= e.nmsr; e_hnd <= e.hnd;
      end
      if (cfg_we) begin
        if (cfg_addr < 22) m_ofs[cfg_addr] = cfg_data[15:0];
        else if (cfg_addr == 31) m_pfx = cfg_data;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      chk("R1 done", 32'(done_o), 32'(e_done));
      chk("R3 err", 32'(err_o), 32'(e_err));
      chk("R3 save_we", 32'(save_we_o), 32'(e_we));
      chk("R6 alt_we", 32'(alt_we_o), 32'(e_alt));
      chk("R5 pair", 32'(save_pair_o), 32'(e_pair));
      chk("R8 save_pc", save_pc_o, e_spc);
      chk("R7 save_msr", save_msr_o, e_smsr);
      chk("R9 new_msr", new_msr_o, e_nmsr);
      chk("R2 handler", handler_o, e_hnd);
    end
  end

  task automatic cfg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic entry(input logic [15:0] c, input logic [1:0] f, input logic [31:0] pc,
                       input logic [31:0] m, input logic [15:0] cs);
    @(negedge clk);
    valid_i = 1; code_i = c; flavour_i = f; pc_i = pc; msr_i = m; cause_i = cs;
    @(negedge clk);
    valid_i = 0;
  endtask

  localparam logic [31:0] MSR0 = 32'h0207_1032;
  localparam logic [31:0] PFX  = 32'hABC0_0000;

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] codes [22];
    logic [31:0] lcg;
    codes = '{16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0500, 16'h0600, 16'h0700, 16'h0800,
              16'h0C00, 16'h0F20, 16'h1000, 16'h1010, 16'h1020, 16'h1100, 16'h1200, 16'h2000,
              16'h2200, 16'h2240, 16'h22A0, 16'h22C0, 16'h0900, 16'h2010};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset done", 32'(done_o), 0);
    chk("R1 reset handler", handler_o, 0);
    chk("R1 reset new_msr", new_msr_o, 0);
    for (int k = 0; k < 22; k++) cfg(5'(k), 32'h0100 + 32'(k) * 32'h10);
    cfg(5'd31, PFX);
    cfg(5'd25, 32'hFFFF_FFFF);   // unmapped address, no effect
    run_cmp = 1;

    // R2 R4 R9 R11: vectored instruction storage
    entry(16'h0400, 2'd2, 32'h1000, MSR0, 16'h00C0);
    chk("R2 R4 isi handler", handler_o, 32'hABC0_0130);
    chk("R11 isi saved", save_msr_o, 32'h0000_10F2);
    chk("R9 isi new", new_msr_o, 32'h8203_1001);
    chk("R8 isi pc", save_pc_o, 32'h1000);
    // R6: vectored machine check
    entry(16'h0200, 2'd2, 32'h2000, MSR0, 16'h0);
    chk("R6 mchk alt", 32'(alt_we_o), 1);
    chk("R5 mchk pair", 32'(save_pair_o), 3);
    chk("R6 mchk new", new_msr_o, 32'h8201_0001);
    chk("R6 mchk saved", save_msr_o, MSR0);
    // R7 R8: program trap and fp
    entry(16'h0700, 2'd2, 32'h3000, MSR0, 16'h2);
    chk("R4 trap handler", handler_o, 32'hABC0_01F0);
    chk("R7 trap saved", save_msr_o, 32'h0002_1032);
    chk("R8 trap pc", save_pc_o, 32'h2FFC);
    entry(16'h0700, 2'd2, 32'h3000, MSR0, 16'h1);
    chk("R7 fp saved", save_msr_o, 32'h0004_1032);
    chk("R4 fp handler", handler_o, 32'hABC0_0160);
    entry(16'h0700, 2'd0, 32'h3000, MSR0, 16'h3);
    chk("R7 other saved", save_msr_o, 32'h0001_1032);
    chk("R10 classic handler", handler_o, 32'h0000_0700);
    chk("R9 classic new", new_msr_o, 32'h0203_1001);
    // R10: classic reset vector, both IP settings
    entry(16'h0100, 2'd0, 32'h40, MSR0 | 32'h40, 16'h0);
    chk("R10 reset ip", handler_o, 32'hFFCF_FD00);
    entry(16'h0100, 2'd3, 32'h40, MSR0, 16'h0);
    chk("R10 reset no ip", handler_o, 32'hFFC0_0100);
    // R5: reset pairs
    entry(16'h0100, 2'd1, 32'h40, MSR0, 16'h0);
    chk("R5 4xx reset pair", 32'(save_pair_o), 1);
    chk("R10 4xx reset handler", handler_o, 32'h100);
    entry(16'h0100, 2'd2, 32'h40, MSR0, 16'h0);
    chk("R5 emb reset pair", 32'(save_pair_o), 2);
    entry(16'h1020, 2'd2, 32'h50, MSR0, 16'h0);
    chk("R5 wdog pair", 32'(save_pair_o), 2);
    chk("R4 wdog handler", handler_o, 32'hABC0_01C0);
    // R3: index 18 in vectored flavour, unknown code in classic
    entry(16'h2040, 2'd2, 32'h60, 32'h0, 16'h0);
    chk("R3 gap err", 32'(err_o), 1);
    chk("R3 gap no write", 32'(save_we_o), 0);
    chk("R3 gap hold", handler_o, 32'hABC0_01C0);
    entry(16'h0900, 2'd0, 32'h60, 32'h0, 16'h0);
    chk("R3 unknown err", 32'(err_o), 1);
    // R2: upper bank
    entry(16'h2200, 2'd2, 32'h70, MSR0, 16'h0);
    chk("R2 bank1 first", handler_o, 32'hABC0_0200);
    entry(16'h22A0, 2'd2, 32'h70, MSR0, 16'h0);
    chk("R2 bank1 last", handler_o, 32'hABC0_0250);
    entry(16'h0C00, 2'd2, 32'h80, MSR0, 16'h0);
    chk("R4 syscall handler", handler_o, 32'hABC0_0180);
    entry(16'h0600, 2'd0, 32'h90, MSR0, 16'h0);
    chk("R8 align pc", save_pc_o, 32'h8C);

    // R2: write and entry in the same cycle use the old offset
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'd3; cfg_data = 32'h0777;
    valid_i = 1; code_i = 16'h0400; flavour_i = 2'd2; pc_i = 32'h10; msr_i = MSR0; cause_i = 0;
    @(negedge clk);
    cfg_we = 0; valid_i = 0;
    chk("R2 same cycle old", handler_o, 32'hABC0_0130);
    entry(16'h0400, 2'd2, 32'h10, MSR0, 16'h0);
    chk("R2 after write", handler_o, 32'hABC0_0777);

    // sweep against the model, back to back
    lcg = 32'h1234_5678;
    for (int r = 0; r < 3; r++) begin
      for (int f = 0; f < 4; f++) begin
        for (int i = 0; i < 22; i++) begin
          @(negedge clk);
          lcg = lcg * 32'd1664525 + 32'd1013904223;
          valid_i = 1; code_i = codes[i]; flavour_i = 2'(f);
          pc_i = lcg ^ 32'h0000_0F00; msr_i = {lcg[15:0], lcg[31:16]}; cause_i = lcg[23:8];
        end
      end
    end
    @(negedge clk);
    valid_i = 0;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule